// File: doc/BRIEF.md
# Status Flag and Standby Release Unit

This block holds the one-bit status flag of a small 4-bit controller core. When the decoder issues a status-test instruction, the block checks a condition chosen by a 4-bit operand and writes the result into the flag. The condition is built from the key-input pins, the timer-zero indication and the switch lines. The block also remembers that operand. The condition it selects, applied to the live inputs, is the release condition used by the halt instruction.

On a halt, the core does one of three things. It skips standby and sets the flag when the release condition already holds. It skips standby and clears the flag when the flag was set. Otherwise it enters standby. Standby lasts until the release condition becomes true. The block then leaves standby, sets the flag and raises a release pulse for one cycle. Every condition source passes through a two-flop synchronizer before it is used. This includes the switch-2 enable and the timer-zero line, so that all sources line up in time.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous active-low reset clears the flag, standby and the release pulse, and sets the remembered operand to 0000, which selects no condition.
- R2: A status test sets the flag to 1 when the condition chosen by `test_op` is true and clears it to 0 otherwise. The operand is remembered as the release operand.
- R3: Operand bits [2:0] select the base condition: 001 and 010 select any key input high, 100 selects timer zero, and 111 selects any key input high or timer zero. 000, 011, 101 and 110 select nothing.
- R4: Operand bit 3 ORs in one more term: at least one enabled switch line is high.
- R5: Switch line 2 (`sw_in[2]`) counts only while `s2_wake_en` is 1. Lines 0 and 1 always count.
- R6: A halt while the release condition is true sets the flag to 1, and standby is not entered.
- R7: A halt while the flag is 1 and the release condition is false clears the flag, and standby is not entered.
- R8: A halt while the flag is 0 and the release condition is false enters standby, and the flag stays 0.
- R9: In standby, once the release condition becomes true, the block leaves standby and sets the flag. `release_pulse` is high for exactly the one cycle after the exit edge.
- R10: The release condition uses the operand of the most recent status test, applied to the current inputs.
- R11: Strobes are ignored while in standby. When both strobes arrive in the same cycle, the test is carried out and the halt is dropped.
- R12: A pin change reaches a decision at the third rising edge after it: standby drops on that edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_in | input | KEY_W | Key-input pins |
| sw_in | input | N_SW | Switch lines; the top lane is gated |
| s2_wake_en | input | 1 | Enable for the top switch lane |
| tmr_zero | input | 1 | Timer down counter is zero |
| test_op | input | 4 | Status-test operand |
| test_stb | input | 1 | Status-test instruction strobe |
| halt_stb | input | 1 | Halt instruction strobe |
| status_flag | output | 1 | Status flag |
| standby | output | 1 | Core is in standby |
| release_pulse | output | 1 | One-cycle pulse on standby exit |

## Verification
The hardest state to reach is standby itself. It needs a halt issued while the flag is 0 and the remembered operand sees no true condition. Leaving standby then needs pins that satisfy that particular operand. The random stimulus holds the pins for three cycles before every strobe and mixes tests with halts, so flag-clear and standby paths both occur. A directed sequence sets a standby exit and checks the synchronizer delay edge by edge. Runs that lock into an operand that can never release are ended by a reset.

// File: rtl/sflag_pkg.sv
// Shared types for the status flag unit.
// Assumes: nothing beyond a two-state run/standby machine.
package sflag_pkg;
    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_STANDBY = 1'b1
    } sf_state_t;

    localparam int OP_W = 4;
endpackage

// File: rtl/sflag_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes: lanes are independent; multi-bit coherence is not needed.
module sflag_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages, both cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/sflag_cond_eval.sv
// Decodes a test operand into one condition over the synchronized sources.
// Assumes: inputs are already synchronized; purely combinational.
module sflag_cond_eval
    import sflag_pkg::*;
#(
    parameter int KEY_W = 4,
    parameter int N_SW  = 3
) (
    input  logic [KEY_W-1:0] key_s,
    input  logic [N_SW-1:0]  sw_s,
    input  logic             gate_en_s,
    input  logic             tz_s,
    input  logic [OP_W-1:0]  op,
    output logic             hit
);
    localparam int GATED_LANE = N_SW - 1;

    logic [N_SW-1:0] sw_mask;
    logic            key_any;
    logic            sw_any;
    logic            base_hit;

    // Lane mask: only the top switch lane depends on the enable.
    for (genvar i = 0; i < N_SW; i++) begin : g_mask
        if (i == GATED_LANE) begin : g_gated
            assign sw_mask[i] = gate_en_s;
        end else begin : g_open
            assign sw_mask[i] = 1'b1;
        end
    end

    // Base selection from the low operand bits, then the switch term.
    always_comb begin
        key_any = |key_s;
        sw_any  = |(sw_s & sw_mask);
        unique case (op[2:0])
            3'b001, 3'b010: base_hit = key_any;
            3'b100:         base_hit = tz_s;
            3'b111:         base_hit = key_any | tz_s;
            default:        base_hit = 1'b0;
        endcase
        hit = base_hit | (op[3] & sw_any);
    end
endmodule

// File: rtl/sflag_ctrl.sv
// Flag, standby state and release pulse sequencing.
// Assumes: strobes are single-cycle; test_hit/rel_hit come from the evaluators.
module sflag_ctrl
    import sflag_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            test_stb,
    input  logic            halt_stb,
    input  logic [OP_W-1:0] test_op,
    input  logic            test_hit,
    input  logic            rel_hit,
    output logic [OP_W-1:0] rel_op,
    output logic            flag,
    output logic            in_standby,
    output logic            rel_pulse
);
    sf_state_t state_q;

    // Instruction handling while running, wake detection while in standby.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            flag      <= 1'b0;
            rel_op    <= '0;
            rel_pulse <= 1'b0;
        end else begin
            rel_pulse <= 1'b0;
            unique case (state_q)
                ST_RUN: begin
                    if (test_stb) begin
                        flag   <= test_hit;
                        rel_op <= test_op;
                    end else if (halt_stb) begin
                        if (rel_hit) begin
                            flag <= 1'b1;
                        end else if (flag) begin
                            flag <= 1'b0;
                        end else begin
                            state_q <= ST_STANDBY;
                        end
                    end
                end
                ST_STANDBY: begin
                    if (rel_hit) begin
                        state_q   <= ST_RUN;
                        flag      <= 1'b1;
                        rel_pulse <= 1'b1;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    assign in_standby = (state_q == ST_STANDBY);
endmodule

// File: rtl/status_flag_unit.sv
// Top of the status flag unit: synchronizes sources, evaluates the test and
// release conditions, and sequences flag and standby.
// Assumes: test_op is valid whenever test_stb is high.
module status_flag_unit
    import sflag_pkg::*;
#(
    parameter int KEY_W = 4,
    parameter int N_SW  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key_in,
    input  logic [N_SW-1:0]  sw_in,
    input  logic             s2_wake_en,
    input  logic             tmr_zero,
    input  logic [OP_W-1:0]  test_op,
    input  logic             test_stb,
    input  logic             halt_stb,
    output logic             status_flag,
    output logic             standby,
    output logic             release_pulse
);
    localparam int SYNC_W = KEY_W + N_SW + 2;

    logic [SYNC_W-1:0] raw_vec;
    logic [SYNC_W-1:0] syn_vec;
    logic [KEY_W-1:0]  key_s;
    logic [N_SW-1:0]   sw_s;
    logic              gate_en_s;
    logic              tz_s;
    logic [OP_W-1:0]   rel_op;
    logic              test_hit;
    logic              rel_hit;

    // Pack every condition source into one synchronizer vector.
    assign raw_vec = {s2_wake_en, tmr_zero, sw_in, key_in};
    assign {gate_en_s, tz_s, sw_s, key_s} = syn_vec;

    sflag_sync #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_vec),
        .d_sync  (syn_vec)
    );

    sflag_cond_eval #(.KEY_W(KEY_W), .N_SW(N_SW)) u_test_eval (
        .key_s     (key_s),
        .sw_s      (sw_s),
        .gate_en_s (gate_en_s),
        .tz_s      (tz_s),
        .op        (test_op),
        .hit       (test_hit)
    );

    sflag_cond_eval #(.KEY_W(KEY_W), .N_SW(N_SW)) u_rel_eval (
        .key_s     (key_s),
        .sw_s      (sw_s),
        .gate_en_s (gate_en_s),
        .tz_s      (tz_s),
        .op        (rel_op),
        .hit       (rel_hit)
    );

    sflag_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_stb   (test_stb),
        .halt_stb   (halt_stb),
        .test_op    (test_op),
        .test_hit   (test_hit),
        .rel_hit    (rel_hit),
        .rel_op     (rel_op),
        .flag       (status_flag),
        .in_standby (standby),
        .rel_pulse  (release_pulse)
    );
endmodule

// File: rtl/sflag_checker.sv
// Temporal checks on the status flag unit, bound onto its top.
// Assumes: test_hit and rel_hit are the evaluator outputs inside the top.
module sflag_checker (
    input logic clk,
    input logic rst_n,
    input logic test_stb,
    input logic halt_stb,
    input logic status_flag,
    input logic standby,
    input logic release_pulse,
    input logic test_hit,
    input logic rel_hit
);
    a_r2_test_loads_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (test_stb && !standby) |=> (status_flag == $past(test_hit)));

    a_r6_halt_release_true: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_stb && !test_stb && !standby && rel_hit) |=> (status_flag && !standby));

    a_r7_halt_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_stb && !test_stb && !standby && !rel_hit && status_flag)
            |=> (!status_flag && !standby));

    a_r8_standby_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby) |-> ($past(halt_stb) && !$past(status_flag) && !status_flag));

    a_r8_flag_low_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !status_flag);

    a_r9_pulse_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |-> (!standby && status_flag && $past(standby)));

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |=> !release_pulse);

    a_r11_standby_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !rel_hit) |=> standby);
endmodule

bind status_flag_unit sflag_checker u_sflag_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .test_stb      (test_stb),
    .halt_stb      (halt_stb),
    .status_flag   (status_flag),
    .standby       (standby),
    .release_pulse (release_pulse),
    .test_hit      (test_hit),
    .rel_hit       (rel_hit)
);

// File: tb/test_status_flag_unit.sv
module test_status_flag_unit;
    localparam int KEY_W = 4;
    localparam int N_SW  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [KEY_W-1:0] key_in = '0;
    logic [N_SW-1:0]  sw_in = '0;
    logic             s2_wake_en = 1'b0;
    logic             tmr_zero = 1'b0;
    logic [3:0]       test_op = '0;
    logic             test_stb = 1'b0;
    logic             halt_stb = 1'b0;
    logic             status_flag, standby, release_pulse;

    int checks = 0;
    int errors = 0;

    logic       ref_flag = 1'b0;
    logic       ref_sb = 1'b0;
    logic [3:0] ref_op = '0;

    always #4 clk = ~clk;

    status_flag_unit #(.KEY_W(KEY_W), .N_SW(N_SW)) i_status_flag_unit (
        .clk(clk), .rst_n(rst_n), .key_in(key_in), .sw_in(sw_in),
        .s2_wake_en(s2_wake_en), .tmr_zero(tmr_zero), .test_op(test_op),
        .test_stb(test_stb), .halt_stb(halt_stb), .status_flag(status_flag),
        .standby(standby), .release_pulse(release_pulse)
    );

    function automatic logic f_cond(logic [3:0] op, logic [KEY_W-1:0] k,
                                    logic [N_SW-1:0] s, logic en, logic tz);
        logic base;
        logic swh;
        case (op[2:0])
            3'b001, 3'b010: base = |k;
            3'b100:         base = tz;
            3'b111:         base = (|k) | tz;
            default:        base = 1'b0;
        endcase
        swh = s[0] | s[1] | (s[2] & en);
        return base | (op[3] & swh);
    endfunction

    function automatic logic f_live(logic [3:0] op);
        return f_cond(op, key_in, sw_in, s2_wake_en, tmr_zero);
    endfunction

    task automatic chk(logic ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_all(string req, logic exp_pulse);
        chk(status_flag == ref_flag, req, status_flag, ref_flag);
        chk(standby == ref_sb, req, standby, ref_sb);
        chk(release_pulse == exp_pulse, req, release_pulse, exp_pulse);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; test_stb = 0; halt_stb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ref_flag = 0; ref_sb = 0; ref_op = '0;
        // R1: reset state
        chk_all("R1", 1'b0);
    endtask

    // Apply pins, let them cross the synchronizer, check any standby exit.
    task automatic set_pins(logic [KEY_W-1:0] k, logic [N_SW-1:0] s,
                            logic en, logic tz, string req);
        logic exp_p;
        @(negedge clk);
        key_in = k; sw_in = s; s2_wake_en = en; tmr_zero = tz;
        repeat (3) @(negedge clk);
        exp_p = ref_sb && f_live(ref_op);
        if (exp_p) begin
            ref_sb = 0; ref_flag = 1;
        end
        chk_all(req, exp_p);
    endtask

    // One-cycle strobe; expected state from the requirements.
    task automatic strobe(logic t, logic h, logic [3:0] op, string req);
        test_stb = t; halt_stb = h; test_op = op;
        @(negedge clk);
        test_stb = 0; halt_stb = 0;
        if (!ref_sb) begin
            if (t) begin
                ref_flag = f_live(op);
                ref_op = op;
            end else if (h) begin
                if (f_live(ref_op)) ref_flag = 1;
                else if (ref_flag) ref_flag = 0;
                else ref_sb = 1;
            end
        end
        chk_all(req, 1'b0);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        do_reset();

        // R1: remembered operand is 0000 after reset, so halt enters standby
        set_pins(4'hF, 3'b111, 1, 1, "R1");
        strobe(0, 1, 4'h0, "R1");
        chk(standby == 1'b1, "R1", standby, 1);
        do_reset();

        // R3: 0000 and 0011 select nothing even with keys high
        set_pins(4'b0100, 3'b000, 0, 1, "R3");
        strobe(1, 0, 4'b0000, "R3");
        chk(status_flag == 0, "R3", status_flag, 0);
        strobe(1, 0, 4'b0011, "R3");
        strobe(1, 0, 4'b0001, "R3");
        chk(status_flag == 1, "R3", status_flag, 1);
        strobe(1, 0, 4'b0100, "R3");
        set_pins(4'b0000, 3'b000, 0, 0, "R3");
        strobe(1, 0, 4'b0111, "R3");
        chk(status_flag == 0, "R2", status_flag, 0);

        // R4 / R5: switch lane 2 gated by enable
        set_pins(4'b0000, 3'b100, 0, 0, "R5");
        strobe(1, 0, 4'b1000, "R5");
        chk(status_flag == 0, "R5", status_flag, 0);
        set_pins(4'b0000, 3'b100, 1, 0, "R5");
        strobe(1, 0, 4'b1000, "R5");
        chk(status_flag == 1, "R5", status_flag, 1);
        set_pins(4'b0000, 3'b001, 0, 0, "R4");
        strobe(1, 0, 4'b1000, "R4");
        chk(status_flag == 1, "R4", status_flag, 1);

        // R7: flag 1, release false -> flag cleared, no standby
        set_pins(4'b0000, 3'b000, 0, 0, "R7");
        strobe(0, 1, 4'h0, "R7");
        chk(status_flag == 0 && standby == 0, "R7", {status_flag, standby}, 0);
        // R8: flag 0, release false -> standby
        strobe(0, 1, 4'h0, "R8");
        chk(standby == 1, "R8", standby, 1);
        // R11: strobes ignored in standby
        strobe(1, 0, 4'b0001, "R11");
        strobe(0, 1, 4'b0001, "R11");
        chk(standby == 1, "R11", standby, 1);

        // R12: exit appears on the third edge after the pin change (op 1000 latched)
        @(negedge clk);
        sw_in = 3'b010;
        repeat (2) @(negedge clk);
        chk(standby == 1, "R12", standby, 1);
        @(negedge clk);
        ref_sb = 0; ref_flag = 1;
        // R9: exit, flag set, pulse for one cycle
        chk_all("R9", 1'b1);
        @(negedge clk);
        chk(release_pulse == 0, "R9", release_pulse, 0);

        // R6 / R10: halt with remembered operand already true
        strobe(0, 1, 4'h0, "R6");
        chk(status_flag == 1 && standby == 0, "R6", standby, 0);
        set_pins(4'b0000, 3'b000, 0, 1, "R10");
        strobe(1, 0, 4'b0100, "R10");
        set_pins(4'b0000, 3'b000, 0, 0, "R10");
        strobe(0, 1, 4'h0, "R10");
        chk(status_flag == 0, "R10", status_flag, 0);
        strobe(0, 1, 4'h0, "R10");
        set_pins(4'b0000, 3'b000, 0, 1, "R10");
        chk(standby == 0, "R10", standby, 0);

        // R11: both strobes -> test wins
        set_pins(4'b0000, 3'b000, 0, 0, "R11");
        strobe(1, 1, 4'b0000, "R11");
        chk(standby == 0, "R11", standby, 0);

        // Random mix of pins and instructions (R2, R6, R7, R8, R9)
        for (int n = 0; n < 400; n++) begin
            int act;
            if (ref_sb && !f_cond(ref_op, '1, '1, 1'b1, 1'b1)) do_reset();
            set_pins(KEY_W'($urandom_range(0, 3) == 0 ? $urandom : 0),
                     N_SW'($urandom_range(0, 2) == 0 ? $urandom : 0),
                     1'($urandom), 1'($urandom_range(0, 3) == 0), "R9");
            act = $urandom_range(0, 3);
            strobe(act == 1 || act == 3, act >= 2, 4'($urandom), "R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule